// File: doc/BRIEF.md
# 100BASE-X Receive Start-of-Stream Delimiter Detector

This block sits on the receive side of a 100BASE-X coding sublayer, directly after the descrambler. It takes one 5B code bit per clock and keeps the last ten bits in a sliding window. While the line is idle it watches for the first zero bit. Seven bits after that zero arrives, it decides whether the window holds the two-symbol start delimiter /J/K/ (J = 11000, K = 10001, sent MSB first). If it does, the block raises carrier sense and receive-data-valid. It then emits two preamble nibbles (0x5) in place of /J/K/ and decodes each later symbol on the 5-bit boundary locked at the match. Any other pattern is treated as a false carrier: carrier sense is raised alone and no data is produced.

Reception and false carrier both end after a run of consecutive aligned idle symbols (I = 11111), two by default. A small transmit-side companion is included. On a 5B symbol stream it replaces the first symbol of each packet with J and the next valid symbol with K, and passes every other symbol through one clock later.

Top module: `pcs_ssd_unit`

## Requirements
- R1: After reset, rx_crs, rx_dv, rx_false_carrier, rx_nib_valid and tx_out_valid are all 0.
- R2: A stream of only 1 bits leaves rx_crs, rx_dv and rx_false_carrier at 0 and produces no nibble.
- R3: In idle, on the clock edge that captures the last bit of a /J/K/ pair (bits 1100010001, oldest first), rx_crs and rx_dv become 1 and rx_nib_valid pulses with rx_nib = 0x5.
- R4: Within a packet, rx_nib_valid pulses exactly every 5 clocks. The second pulse carries 0x5 (the K substitute), and each later pulse carries the data of the 5B symbol received one symbol earlier.
- R5: Data symbols decode with the standard 4B5B table (0:11110, 1:01001, 2:10100, 3:10101, 4:01010, 5:01011, 6:01110, 7:01111, 8:10010, 9:10011, A:10110, B:10111, C:11010, D:11011, E:11100, F:11101). Any other aligned symbol yields nibble 0x0.
- R6: During reception, IDLE_END_SYMS (default 2) consecutive aligned /I/ symbols end the packet. On the edge capturing the last of them, rx_crs and rx_dv go to 0 and no further nibble is emitted. A single /I/ between data symbols does not end the packet; it is emitted as nibble 0x0.
- R7: In idle, when the first zero bit has been followed by 7 more bits and the 10-bit window is not /J/K/, rx_crs and rx_false_carrier become 1, while rx_dv stays 0 and no nibble is emitted.
- R8: A false carrier ends after IDLE_END_SYMS consecutive aligned /I/ symbols. A later /J/K/ is then detected normally.
- R9: Detection does not depend on how many idle bits precede /J/K/ (any bit offset).
- R10: A J followed by any symbol other than K is a false carrier, not a packet start.
- R11: On tx, a valid symbol with tx_sop set comes out as J (11000). The next valid symbol without tx_sop comes out as K (10001), even when invalid cycles come in between.
- R12: Every other tx symbol passes unchanged, and tx_out_valid follows tx_sym_valid with one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one code bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_code_bit | input | 1 | Descrambled receive code bit |
| rx_crs | output | 1 | Carrier sense |
| rx_dv | output | 1 | Receive data valid |
| rx_false_carrier | output | 1 | Non-delimiter activity seen in idle |
| rx_nib_valid | output | 1 | Strobe for rx_nib |
| rx_nib | output | 4 | Decoded receive nibble |
| tx_sym_valid | input | 1 | Transmit symbol valid |
| tx_sop | input | 1 | Marks first symbol of a packet |
| tx_sym | input | 5 | Transmit 5B symbol |
| tx_out_valid | output | 1 | Output symbol valid |
| tx_out_sym | output | 5 | Transmit symbol with /J/K/ inserted |

## Verification
The assertions assume that the receive stream is a clean 0 or 1 on every clock and that the line idles as all ones before the first packet. The bit-window invariant in idle (the three oldest bits are ones) relies on this, together with the rule that a zero is classified seven bits after it arrives. On the transmit side they assume tx_sop is only set with tx_sym_valid. The stimulus keeps to these assumptions. It drives a defined bit at every falling edge and begins with idle symbols. It closes every packet and every noise burst with enough /I/ symbols to return the block to idle before the next event, and it raises tx_sop only on valid cycles.

// File: rtl/pcs_ssd_pkg.sv
package pcs_ssd_pkg;
    localparam int SYM_W = 5;
    localparam int NIB_W = 4;

    localparam logic [SYM_W-1:0] CG_J = 5'b11000;
    localparam logic [SYM_W-1:0] CG_K = 5'b10001;
    localparam logic [SYM_W-1:0] CG_I = 5'b11111;
    localparam logic [NIB_W-1:0] NIB_PRE = 4'h5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_FCAR = 2'd2
    } rx_state_e;

    function automatic logic [NIB_W-1:0] dec5(input logic [SYM_W-1:0] c);
        logic [NIB_W-1:0] n;
        case (c)
            5'b11110: n = 4'h0;
            5'b01001: n = 4'h1;
            5'b10100: n = 4'h2;
            5'b10101: n = 4'h3;
            5'b01010: n = 4'h4;
            5'b01011: n = 4'h5;
            5'b01110: n = 4'h6;
            5'b01111: n = 4'h7;
            5'b10010: n = 4'h8;
            5'b10011: n = 4'h9;
            5'b10110: n = 4'hA;
            5'b10111: n = 4'hB;
            5'b11010: n = 4'hC;
            5'b11011: n = 4'hD;
            5'b11100: n = 4'hE;
            5'b11101: n = 4'hF;
            default:  n = 4'h0;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/ssd_bit_window.sv
module ssd_bit_window
    import pcs_ssd_pkg::*;
#(
    parameter int WIN_W = 2 * SYM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_i,
    output logic [WIN_W-1:0] win_next_o,
    output logic [WIN_W-1:0] win_q_o
);
    logic [WIN_W-1:0] win_d, win_q;

    always_comb begin
        win_d = {win_q[WIN_W-2:0], bit_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '1;
        else        win_q <= win_d;
    end

    assign win_next_o = win_d;
    assign win_q_o    = win_q;
endmodule

// File: rtl/ssd_rx_ctrl.sv
module ssd_rx_ctrl
    import pcs_ssd_pkg::*;
#(
    parameter int IDLE_END_SYMS = 2,
    parameter int WIN_W         = 2 * SYM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] win_i,
    output logic             crs_o,
    output logic             dv_o,
    output logic             fc_o,
    output logic             nib_v_o,
    output logic [NIB_W-1:0] nib_o
);
    localparam int CNT_W    = $clog2(SYM_W);
    localparam int ICNT_W   = $clog2(IDLE_END_SYMS + 1);
    localparam int TRIG_IDX = WIN_W - 3;
    localparam logic [WIN_W-1:0] PAIR_JK = {CG_J, CG_K};

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [ICNT_W-1:0] icnt;
        logic [NIB_W-1:0]  held;
        logic [NIB_W-1:0]  nib;
        logic              nib_v;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;
    logic              at_edge;
    logic              last_idle;
    logic [CNT_W-1:0]  cnt_step;
    logic [SYM_W-1:0]  sym;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.nib_v = 1'b0;
        at_edge     = (ctl_q.cnt == CNT_W'(SYM_W - 1));
        cnt_step    = at_edge ? '0 : ctl_q.cnt + 1'b1;
        sym         = win_i[SYM_W-1:0];
        last_idle   = (ctl_q.icnt == ICNT_W'(IDLE_END_SYMS - 1));
        case (ctl_q.st)
            ST_IDLE: begin
                if (!win_i[TRIG_IDX]) begin
                    ctl_d.cnt  = '0;
                    ctl_d.icnt = '0;
                    if (win_i == PAIR_JK) begin
                        ctl_d.st    = ST_DATA;
                        ctl_d.nib   = NIB_PRE;
                        ctl_d.nib_v = 1'b1;
                        ctl_d.held  = NIB_PRE;
                    end else begin
                        ctl_d.st = ST_FCAR;
                    end
                end
            end
            ST_DATA: begin
                ctl_d.cnt = cnt_step;
                if (at_edge) begin
                    if (sym == CG_I && last_idle) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.icnt = '0;
                    end else begin
                        ctl_d.nib   = ctl_q.held;
                        ctl_d.nib_v = 1'b1;
                        ctl_d.held  = dec5(sym);
                        ctl_d.icnt  = (sym == CG_I) ? ctl_q.icnt + 1'b1 : '0;
                    end
                end
            end
            ST_FCAR: begin
                ctl_d.cnt = cnt_step;
                if (at_edge) begin
                    if (sym == CG_I && last_idle) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.icnt = '0;
                    end else begin
                        ctl_d.icnt = (sym == CG_I) ? ctl_q.icnt + 1'b1 : '0;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign crs_o   = (ctl_q.st != ST_IDLE);
    assign dv_o    = (ctl_q.st == ST_DATA);
    assign fc_o    = (ctl_q.st == ST_FCAR);
    assign nib_v_o = ctl_q.nib_v;
    assign nib_o   = ctl_q.nib;

    AST_SSD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && win_i == PAIR_JK) |=> (dv_o && nib_v_o && nib_o == NIB_PRE)); // R3

    AST_NIB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        nib_v_o |=> !nib_v_o); // R4

    AST_FC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fc_o) |-> (!dv_o && !nib_v_o && $past(ctl_q.st == ST_IDLE))); // R7

    AST_FC_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fc_o) |-> ($past(win_i) == '1)); // R8
endmodule

// File: rtl/ssd_tx_insert.sv
module ssd_tx_insert
    import pcs_ssd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             sop_i,
    input  logic [SYM_W-1:0] sym_i,
    output logic             valid_o,
    output logic [SYM_W-1:0] sym_o
);
    typedef struct packed {
        logic             pend_k;
        logic             vld;
        logic [SYM_W-1:0] sym;
    } tx_s;

    tx_s tx_d, tx_q;

    always_comb begin
        tx_d     = tx_q;
        tx_d.vld = valid_i;
        if (valid_i) begin
            if (sop_i) begin
                tx_d.sym    = CG_J;
                tx_d.pend_k = 1'b1;
            end else if (tx_q.pend_k) begin
                tx_d.sym    = CG_K;
                tx_d.pend_k = 1'b0;
            end else begin
                tx_d.sym = sym_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign valid_o = tx_q.vld;
    assign sym_o   = tx_q.sym;

    AST_TX_J: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && sop_i) |=> (valid_o && sym_o == CG_J)); // R11

    AST_TX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !sop_i && !tx_q.pend_k) |=> (valid_o && sym_o == $past(sym_i))); // R12
endmodule

// File: rtl/pcs_ssd_unit.sv
module pcs_ssd_unit
    import pcs_ssd_pkg::*;
#(
    parameter int IDLE_END_SYMS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_code_bit,
    output logic             rx_crs,
    output logic             rx_dv,
    output logic             rx_false_carrier,
    output logic             rx_nib_valid,
    output logic [NIB_W-1:0] rx_nib,
    input  logic             tx_sym_valid,
    input  logic             tx_sop,
    input  logic [SYM_W-1:0] tx_sym,
    output logic             tx_out_valid,
    output logic [SYM_W-1:0] tx_out_sym
);
    localparam int WIN_W = 2 * SYM_W;

    logic [WIN_W-1:0] win_next, win_q;

    ssd_bit_window #(.WIN_W(WIN_W)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_i      (rx_code_bit),
        .win_next_o (win_next),
        .win_q_o    (win_q)
    );

    ssd_rx_ctrl #(.IDLE_END_SYMS(IDLE_END_SYMS), .WIN_W(WIN_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_i   (win_next),
        .crs_o   (rx_crs),
        .dv_o    (rx_dv),
        .fc_o    (rx_false_carrier),
        .nib_v_o (rx_nib_valid),
        .nib_o   (rx_nib)
    );

    ssd_tx_insert u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (tx_sym_valid),
        .sop_i   (tx_sop),
        .sym_i   (tx_sym),
        .valid_o (tx_out_valid),
        .sym_o   (tx_out_sym)
    );

    AST_IDLE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_crs |-> (win_q[WIN_W-1 -: 3] == 3'b111)); // R2

    AST_DV_CRS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |-> (rx_crs && rx_nib_valid)); // R3
endmodule

// File: tb/pcs_ssd_unit_tb.sv
module pcs_ssd_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_code_bit = 1'b1;
    logic       rx_crs, rx_dv, rx_false_carrier, rx_nib_valid;
    logic [3:0] rx_nib;
    logic       tx_sym_valid = 1'b0;
    logic       tx_sop = 1'b0;
    logic [4:0] tx_sym = 5'b0;
    logic       tx_out_valid;
    logic [4:0] tx_out_sym;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0] exp_q[$];
    logic [3:0] pkt[$];
    int gap = 0;
    bit in_pkt = 1'b0;

    localparam logic [4:0] SJ = 5'b11000;
    localparam logic [4:0] SK = 5'b10001;
    localparam logic [4:0] SI = 5'b11111;
    localparam logic [4:0] SP = 5'b01011;

    always #5 clk = ~clk;

    pcs_ssd_unit u_dut (
        .clk(clk), .rst_n(rst_n), .rx_code_bit(rx_code_bit),
        .rx_crs(rx_crs), .rx_dv(rx_dv), .rx_false_carrier(rx_false_carrier),
        .rx_nib_valid(rx_nib_valid), .rx_nib(rx_nib),
        .tx_sym_valid(tx_sym_valid), .tx_sop(tx_sop), .tx_sym(tx_sym),
        .tx_out_valid(tx_out_valid), .tx_out_sym(tx_out_sym)
    );

    function automatic logic [4:0] enc5(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110; 4'h1: return 5'b01001;
            4'h2: return 5'b10100; 4'h3: return 5'b10101;
            4'h4: return 5'b01010; 4'h5: return 5'b01011;
            4'h6: return 5'b01110; 4'h7: return 5'b01111;
            4'h8: return 5'b10010; 4'h9: return 5'b10011;
            4'hA: return 5'b10110; 4'hB: return 5'b10111;
            4'hC: return 5'b11010; 4'hD: return 5'b11011;
            4'hE: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_code_bit = b;
    endtask

    task automatic send_sym(input logic [4:0] s);
        for (int i = 4; i >= 0; i--) send_bit(s[i]);
    endtask

    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    // Monitor: scoreboard pop and nibble spacing
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            gap++;
            if (rx_nib_valid) begin
                if (in_pkt) check(gap == 5, "R4 nibble spacing", gap, 5);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected nibble", rx_nib, 0);
                end else begin
                    logic [3:0] e;
                    e = exp_q.pop_front();
                    check(rx_nib == e, "R5 nibble value", rx_nib, e);
                end
                gap = 0;
                in_pkt = 1'b1;
            end
            if (!rx_dv) in_pkt = 1'b0;
        end
    end

    // Sends idle offset bits, /J/K/, pkt contents, then idles; mid_i inserts one /I/ after that index
    task automatic run_packet(input int offset, input int mid_i);
        for (int i = 0; i < offset; i++) send_bit(1'b1);
        exp_q.push_back(4'h5);
        exp_q.push_back(4'h5);
        send_sym(SJ);
        send_sym(SK);
        settle();
        check(rx_crs && rx_dv && !rx_false_carrier, "R3 crs/dv after J/K",
              {rx_crs, rx_dv, rx_false_carrier}, 3'b110);
        if (offset > 0) check(rx_dv, "R9 offset detect", rx_dv, 1);
        for (int i = 0; i < pkt.size(); i++) begin
            exp_q.push_back(pkt[i]);
            send_sym(enc5(pkt[i]));
            if (i == mid_i) begin
                exp_q.push_back(4'h0);
                send_sym(SI);
            end
        end
        send_sym(SI);
        check(rx_dv, "R6 single idle keeps packet", rx_dv, 1);
        send_sym(SI);
        settle();
        check(!rx_crs && !rx_dv, "R6 end after two idles", {rx_crs, rx_dv}, 0);
        check(exp_q.size() == 0, "R6 all nibbles out", exp_q.size(), 0);
    endtask

    task automatic tx_step(input logic v, input logic s, input logic [4:0] sym,
                           input logic ev, input logic [4:0] es, input string req);
        @(negedge clk);
        tx_sym_valid = v; tx_sop = s; tx_sym = sym;
        settle();
        check(tx_out_valid == ev, req, tx_out_valid, ev);
        if (ev) check(tx_out_sym == es, req, tx_out_sym, es);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        check(!rx_crs && !rx_dv && !rx_false_carrier && !rx_nib_valid && !tx_out_valid,
              "R1 reset state", {rx_crs, rx_dv, rx_false_carrier, rx_nib_valid, tx_out_valid}, 0);

        // R2: long idle
        for (int i = 0; i < 40; i++) begin
            send_bit(1'b1);
            settle();
            check(!rx_crs && !rx_dv && !rx_false_carrier, "R2 idle quiet",
                  {rx_crs, rx_dv, rx_false_carrier}, 0);
        end

        // R3 R4 R5 R6: all sixteen codes
        pkt.delete();
        for (int i = 0; i < 16; i++) pkt.push_back(4'(i));
        run_packet(0, -1);

        // R9: odd offset, single mid-packet idle
        pkt.delete();
        pkt.push_back(4'hA); pkt.push_back(4'h3); pkt.push_back(4'hC); pkt.push_back(4'h7);
        run_packet(3, 1);

        // R7: noise burst
        send_sym(SI);
        send_sym(5'b10101);
        send_sym(SI);
        settle();
        check(rx_crs && rx_false_carrier && !rx_dv, "R7 false carrier",
              {rx_crs, rx_false_carrier, rx_dv}, 3'b110);
        repeat (3) send_sym(SI);
        settle();
        check(!rx_crs && !rx_false_carrier, "R8 false carrier exit",
              {rx_crs, rx_false_carrier}, 0);

        // R10: J followed by non-K
        send_sym(SI);
        send_sym(SJ);
        send_sym(5'b11110);
        settle();
        check(rx_false_carrier && !rx_dv, "R10 J without K", {rx_false_carrier, rx_dv}, 2'b10);
        repeat (4) send_sym(SI);
        settle();
        check(!rx_crs, "R8 idle after J-noise", rx_crs, 0);

        // R8: packet detected after false carrier
        pkt.delete();
        pkt.push_back(4'h1); pkt.push_back(4'hE);
        run_packet(2, -1);

        // R11 R12: transmit insertion
        tx_step(1, 1, SP, 1, SJ, "R11 sop becomes J");
        tx_step(0, 0, SP, 0, 5'b0, "R12 invalid gap");
        tx_step(1, 0, SP, 1, SK, "R11 next becomes K");
        tx_step(1, 0, SP, 1, SP, "R12 preamble passes");
        tx_step(1, 0, 5'b10100, 1, 5'b10100, "R12 data passes");
        tx_step(1, 1, SP, 1, SJ, "R11 second sop J");
        tx_step(1, 1, SP, 1, SJ, "R11 restart J");
        tx_step(1, 0, SP, 1, SK, "R11 restart K");
        tx_step(0, 0, 5'b0, 0, 5'b0, "R12 valid drops");

        repeat (10) send_bit(1'b1);
        settle();
        check(exp_q.size() == 0, "R2 no stray nibbles", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule